// File: doc/BRIEF.md
# Fast Ethernet Transmit Coding Path

This block turns the nibble stream from a MAC into a three-level line symbol stream for a 100 Mb/s twisted-pair transmitter. Once per nibble slot it samples transmit enable, transmit error and four data bits, and picks one 5-bit code group. The code group is a start delimiter, a data code, an error code, an end delimiter or idle. The stream of code groups is shifted out one bit per bit clock, most significant code bit first. Each bit is XORed with a free-running key sequence, and the result drives a three-level line encoder.

Everything runs on the 125 MHz bit clock. The nibble rate comes from a clock enable, `nib_ce`, which the surrounding logic pulses high for one bit clock in every five. The output is a 2-bit signed symbol per bit time. Analog drive, clock generation and line termination belong to other blocks.

Top module: `fe_tx_coder`

## Requirements
- R1: While `rst_n` is low, `line_sym` is 00, meaning zero. Every nibble slot after release is scrambled with a key sequence restarted from the seed, which is all ones by default.
- R2: In a slot where `tx_en` is low and no packet is ending, the code group is idle (11111). `txd` and `tx_err` have no effect in such a slot.
- R3: The first slot with `tx_en` high emits J (11000) in place of its nibble. The second slot emits K (10001) in place of its nibble.
- R4: From the third slot on, while `tx_en` stays high, each nibble maps to a code group as follows. 0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101.
- R5: A data slot with both `tx_en` and `tx_err` high emits H (00100) instead of the data code group. The next slot without error encodes normally.
- R6: If `tx_err` is seen in the J or K slot, the first data slot of that packet emits H and later slots encode normally. If the packet ends before any data slot, that pending error is discarded.
- R7: The first slot with `tx_en` low after J, K or data emits T (01101), and the next slot emits R (00111) whatever the inputs are. The slot after R starts a new packet with J if `tx_en` is high, and emits idle otherwise.
- R8: Each serial code bit p(n) goes out as p(n) XOR k(n). Here k(n) = L[10] XOR L[8], the register L updates to {L[9:0], k(n)} every bit clock, and L holds the seed at the first edge after reset release.
- R9: A code group sampled at a `nib_ce` edge E is serialized bit 4 first. Bit i of the group (i = 4..0) decides the line transition at edge E+3+(4-i).
- R10: `line_sym` encodes 00 as zero, 01 as +1 and 11 as -1, and it never shows 10. A scrambled 1 moves the line one step around the cycle 0, +1, 0, -1, 0. A scrambled 0 holds the current level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nib_ce | input | 1 | Nibble-slot enable, high one clock in every five |
| tx_en | input | 1 | Transmit enable, sampled when `nib_ce` is high |
| tx_err | input | 1 | Transmit error, sampled when `nib_ce` is high |
| txd | input | 4 | Transmit data nibble |
| line_sym | output | 2 | Signed line symbol: 00 zero, 01 +1, 11 -1 |

## Verification
The code group chosen at a `nib_ce` edge E reaches the line as transitions on edges E+3 through E+7. Its first bit passes a load stage, the shift register and the scrambler register before the line encoder moves.

The bench samples `line_sym` at every falling edge and turns each level change into a scrambled bit. It removes the key with its own copy of the R8 sequence, counted from the first edge after reset release. It compares the accumulated five bits only when the edge count equals 2 modulo 5, which is exactly seven edges after the slot's `nib_ce` edge. Reset behaviour is checked at falling edges while reset is held, and again after a mid-run reset when the first idle slots must decode with a fresh seed.

// File: rtl/fe_tx_pkg.sv
package fe_tx_pkg;

   localparam int NIB_W = 4;
   localparam int CG_W  = 5;

   typedef logic [CG_W-1:0] cg_t;

   // special code groups, bit 4 leaves first
   localparam cg_t CG_IDLE = 5'b11111;
   localparam cg_t CG_J    = 5'b11000;
   localparam cg_t CG_K    = 5'b10001;
   localparam cg_t CG_T    = 5'b01101;
   localparam cg_t CG_R    = 5'b00111;
   localparam cg_t CG_H    = 5'b00100;

   // signed line symbols
   localparam logic [1:0] SYM_ZERO = 2'b00;
   localparam logic [1:0] SYM_POS  = 2'b01;
   localparam logic [1:0] SYM_NEG  = 2'b11;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_SEC  = 2'd1,
      FR_DATA = 2'd2,
      FR_TAIL = 2'd3
   } fr_state_e;

   function automatic cg_t enc_4b5b(input logic [NIB_W-1:0] nib);
      cg_t c;
      case (nib)
         4'h0: c = 5'b11110;
         4'h1: c = 5'b01001;
         4'h2: c = 5'b10100;
         4'h3: c = 5'b10101;
         4'h4: c = 5'b01010;
         4'h5: c = 5'b01011;
         4'h6: c = 5'b01110;
         4'h7: c = 5'b01111;
         4'h8: c = 5'b10010;
         4'h9: c = 5'b10011;
         4'hA: c = 5'b10110;
         4'hB: c = 5'b10111;
         4'hC: c = 5'b11010;
         4'hD: c = 5'b11011;
         4'hE: c = 5'b11100;
         default: c = 5'b11101;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/fe_tx_framer.sv
module fe_tx_framer
   import fe_tx_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nib_ce,
   input  logic             tx_en,
   input  logic             tx_err,
   input  logic [NIB_W-1:0] txd,
   output cg_t              code_q,
   output logic             load_q
);

   fr_state_e st_q, st_d;
   logic      pend_q, pend_d;
   cg_t       code_d;

   // next code group per slot (R2 R3 R4 R5 R6 R7)
   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      code_d = code_q;
      case (st_q)
         FR_IDLE: begin
            if (tx_en) begin
               code_d = CG_J;
               st_d   = FR_SEC;
               pend_d = tx_err;
            end else begin
               code_d = CG_IDLE;
               pend_d = 1'b0;
            end
         end
         FR_SEC: begin
            if (tx_en) begin
               code_d = CG_K;
               st_d   = FR_DATA;
               pend_d = pend_q | tx_err;
            end else begin
               code_d = CG_T;
               st_d   = FR_TAIL;
               pend_d = 1'b0;
            end
         end
         FR_DATA: begin
            if (tx_en) begin
               code_d = (tx_err || pend_q) ? CG_H : enc_4b5b(txd);
               pend_d = 1'b0;
            end else begin
               code_d = CG_T;
               st_d   = FR_TAIL;
               pend_d = 1'b0;
            end
         end
         default: begin
            code_d = CG_R;
            st_d   = FR_IDLE;
            pend_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= FR_IDLE;
         pend_q <= 1'b0;
         code_q <= CG_IDLE;
         load_q <= 1'b0;
      end else begin
         load_q <= nib_ce;
         if (nib_ce) begin
            st_q   <= st_d;
            pend_q <= pend_d;
            code_q <= code_d;
         end
      end
   end

   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_ce && !tx_en) |=> (code_q == CG_IDLE || code_q == CG_T || code_q == CG_R)); // R2
   AST_K_AFTER_J: assert property (@(posedge clk) disable iff (!rst_n)
      (load_q && code_q == CG_K) |-> ($past(code_q, 5) == CG_J)); // R3
   AST_ERR_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (nib_ce && tx_en && tx_err) |=>
         (code_q == CG_H || code_q == CG_J || code_q == CG_K || code_q == CG_R)); // R5
   AST_R_AFTER_T: assert property (@(posedge clk) disable iff (!rst_n)
      (load_q && code_q == CG_R) |-> ($past(code_q, 5) == CG_T)); // R7

endmodule

// File: rtl/fe_tx_serializer.sv
module fe_tx_serializer #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] par,
   output logic         ser
);

   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [W-1:0]  sr_q;
   logic [CW-1:0] cnt_q;
   logic          armed_q;

   initial begin : p_param_chk
      assert (W >= 2) else $fatal(1, "serializer width too small");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q    <= '1;
         cnt_q   <= LAST;
         armed_q <= 1'b0;
      end else if (load) begin
         sr_q    <= par;
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else begin
         sr_q <= {sr_q[W-2:0], 1'b1};
         if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      end
   end

   // most significant code bit leaves first
   assign ser = sr_q[W-1];

   AST_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      (load && armed_q) |-> (cnt_q == LAST)); // R9

endmodule

// File: rtl/fe_tx_scrambler.sv
module fe_tx_scrambler #(
   parameter int             W      = 11,
   parameter int             TAP    = 9,
   parameter logic [W-1:0]   SEED   = '1,
   parameter bit             ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic plain,
   output logic scr
);

   initial begin : p_param_chk
      assert (W >= 3) else $fatal(1, "key register too short");
      assert (TAP >= 1 && TAP < W) else $fatal(1, "tap outside key register");
      assert (SEED != '0) else $fatal(1, "seed must be nonzero");
   end

   generate
      if (ENABLE) begin : g_on
         logic [W-1:0] lfsr_q;
         logic         key;

         assign key = lfsr_q[W-1] ^ lfsr_q[TAP-1];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lfsr_q <= SEED;
               scr    <= 1'b0;
            end else begin
               lfsr_q <= {lfsr_q[W-2:0], key};
               scr    <= plain ^ key;
            end
         end

         AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
            lfsr_q != '0); // R8
      end else begin : g_off
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) scr <= 1'b0;
            else        scr <= plain;
         end
      end
   endgenerate

endmodule

// File: rtl/fe_tx_line_enc.sv
module fe_tx_line_enc
   import fe_tx_pkg::*;
#(
   parameter int LEVELS = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_in,
   output logic [1:0] sym
);

   initial begin : p_param_chk
      assert (LEVELS == 2 || LEVELS == 3) else $fatal(1, "LEVELS must be 2 or 3");
   end

   generate
      if (LEVELS == 3) begin : g_mlt3
         logic [1:0] ph_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ph_q <= 2'd0;
            else if (bit_in) ph_q <= ph_q + 2'd1;
         end

         always_comb begin
            case (ph_q)
               2'd1:    sym = SYM_POS;
               2'd3:    sym = SYM_NEG;
               default: sym = SYM_ZERO;
            endcase
         end

         AST_NO_BAD_SYM: assert property (@(posedge clk) disable iff (!rst_n)
            sym != 2'b10); // R10
         AST_MLT_ADJ: assert property (@(posedge clk) disable iff (!rst_n)
            (sym != $past(sym)) |->
               (($past(sym) == SYM_ZERO) ? (sym != SYM_ZERO) : (sym == SYM_ZERO))); // R10
         AST_MLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(bit_in) |-> $stable(sym)); // R10
      end else begin : g_nrzi
         logic pol_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      pol_q <= 1'b0;
            else if (bit_in) pol_q <= ~pol_q;
         end

         assign sym = pol_q ? SYM_POS : SYM_NEG;
      end
   endgenerate

endmodule

// File: rtl/fe_tx_coder.sv
module fe_tx_coder
   import fe_tx_pkg::*;
#(
   parameter int             KEY_W       = 11,
   parameter int             KEY_TAP     = 9,
   parameter logic [KEY_W-1:0] KEY_SEED  = '1,
   parameter bit             SCRAMBLE    = 1'b1,
   parameter int             LINE_LEVELS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             nib_ce,
   input  logic             tx_en,
   input  logic             tx_err,
   input  logic [NIB_W-1:0] txd,
   output logic [1:0]       line_sym
);

   cg_t  code;
   logic load;
   logic plain_bit;
   logic scr_bit;

   // R1: all stages clear asynchronously, key register reloads the seed
   fe_tx_framer u_framer (
      .clk    (clk),
      .rst_n  (rst_n),
      .nib_ce (nib_ce),
      .tx_en  (tx_en),
      .tx_err (tx_err),
      .txd    (txd),
      .code_q (code),
      .load_q (load)
   );

   fe_tx_serializer #(.W(CG_W)) u_ser (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (load),
      .par   (code),
      .ser   (plain_bit)
   );

   fe_tx_scrambler #(
      .W      (KEY_W),
      .TAP    (KEY_TAP),
      .SEED   (KEY_SEED),
      .ENABLE (SCRAMBLE)
   ) u_scr (
      .clk   (clk),
      .rst_n (rst_n),
      .plain (plain_bit),
      .scr   (scr_bit)
   );

   fe_tx_line_enc #(.LEVELS(LINE_LEVELS)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .bit_in (scr_bit),
      .sym    (line_sym)
   );

endmodule

// File: tb/fe_tx_coder_test.sv
module fe_tx_coder_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       nib_ce = 1'b0;
   logic       tx_en = 1'b0;
   logic       tx_err = 1'b0;
   logic [3:0] txd = 4'h0;
   logic [1:0] line_sym;

   always #4 clk = ~clk;

   fe_tx_coder uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .nib_ce   (nib_ce),
      .tx_en    (tx_en),
      .tx_err   (tx_err),
      .txd      (txd),
      .line_sym (line_sym)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // entry: {en, err, txd[3:0], expected code[4:0], requirement[3:0]}
   localparam int NV1 = 39;
   localparam logic [14:0] VEC1 [NV1] = '{
      {1'b0,1'b0,4'h0,5'b11111,4'd2},   // R2 idle
      {1'b0,1'b1,4'hA,5'b11111,4'd2},   // R2 inputs ignored
      {1'b1,1'b0,4'h5,5'b11000,4'd3},   // R3 J
      {1'b1,1'b0,4'hA,5'b10001,4'd3},   // R3 K
      {1'b1,1'b0,4'h0,5'b11110,4'd4},   // R4
      {1'b1,1'b0,4'h1,5'b01001,4'd4},
      {1'b1,1'b0,4'h2,5'b10100,4'd4},
      {1'b1,1'b0,4'h3,5'b10101,4'd4},
      {1'b1,1'b0,4'h4,5'b01010,4'd4},
      {1'b1,1'b0,4'h5,5'b01011,4'd4},
      {1'b1,1'b0,4'h6,5'b01110,4'd4},
      {1'b1,1'b0,4'h7,5'b01111,4'd4},
      {1'b1,1'b1,4'h8,5'b00100,4'd5},   // R5 H
      {1'b1,1'b0,4'h9,5'b10011,4'd5},   // R5 back to normal
      {1'b1,1'b0,4'hA,5'b10110,4'd4},
      {1'b1,1'b0,4'hB,5'b10111,4'd4},
      {1'b1,1'b0,4'hC,5'b11010,4'd4},
      {1'b1,1'b0,4'hD,5'b11011,4'd4},
      {1'b1,1'b0,4'hE,5'b11100,4'd4},
      {1'b1,1'b0,4'hF,5'b11101,4'd4},
      {1'b0,1'b0,4'h0,5'b01101,4'd7},   // R7 T
      {1'b1,1'b0,4'h3,5'b00111,4'd7},   // R7 R, enable ignored
      {1'b1,1'b0,4'h3,5'b11000,4'd7},   // R7 new packet
      {1'b1,1'b1,4'h4,5'b10001,4'd6},   // R6 error in K slot
      {1'b1,1'b0,4'h6,5'b00100,4'd6},   // R6 pending H
      {1'b1,1'b0,4'h6,5'b01110,4'd6},   // R6 cleared
      {1'b0,1'b0,4'h0,5'b01101,4'd7},
      {1'b0,1'b0,4'h0,5'b00111,4'd7},
      {1'b0,1'b0,4'h0,5'b11111,4'd7},
      {1'b1,1'b1,4'h2,5'b11000,4'd6},   // R6 error in J slot
      {1'b0,1'b0,4'h0,5'b01101,4'd6},   // R6 ends early
      {1'b0,1'b0,4'h0,5'b00111,4'd6},
      {1'b1,1'b0,4'h0,5'b11000,4'd6},
      {1'b1,1'b0,4'h0,5'b10001,4'd6},
      {1'b1,1'b0,4'h0,5'b11110,4'd6},   // R6 no stale H
      {1'b0,1'b0,4'h0,5'b01101,4'd7},
      {1'b0,1'b0,4'h0,5'b00111,4'd7},
      {1'b0,1'b0,4'h0,5'b11111,4'd2},
      {1'b0,1'b1,4'h7,5'b11111,4'd2}
   };

   localparam int NV2 = 9;
   localparam logic [14:0] VEC2 [NV2] = '{
      {1'b0,1'b0,4'h0,5'b11111,4'd1},   // R1 fresh seed
      {1'b0,1'b0,4'h0,5'b11111,4'd1},
      {1'b1,1'b0,4'h2,5'b11000,4'd3},
      {1'b1,1'b0,4'h2,5'b10001,4'd3},
      {1'b1,1'b0,4'hF,5'b11101,4'd4},
      {1'b1,1'b1,4'h1,5'b00100,4'd5},
      {1'b0,1'b0,4'h0,5'b01101,4'd7},
      {1'b0,1'b0,4'h0,5'b00111,4'd7},
      {1'b0,1'b0,4'h0,5'b11111,4'd2}
   };

   localparam logic [10:0] SEED = 11'h7FF;

   logic [4:0] exp_cg  [64];
   logic [3:0] exp_req [64];

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] phase_sym(input int p);
      case (p & 3)
         1: return 2'b01;
         3: return 2'b11;
         default: return 2'b00;
      endcase
   endfunction

   function automatic logic [14:0] vec_at(input int sel, input int s);
      if (sel == 1 && s < NV1) return VEC1[s];
      if (sel == 2 && s < NV2) return VEC2[s];
      return {1'b0, 1'b0, 4'h0, 5'b11111, 4'd2};
   endfunction

   task automatic drive_slot(input int sel, input int s);
      logic [14:0] v;
      v = vec_at(sel, s);
      tx_en  = v[14];
      tx_err = v[13];
      txd    = v[12:9];
      if (s < 64) begin
         exp_cg[s]  = v[8:4];
         exp_req[s] = v[3:0];
      end
   endtask

   // called at the falling edge where reset was just released
   task automatic run_slots(input int sel, input int nslots);
      int cnt;
      logic [10:0] bl;
      logic kprev, key, d, plain;
      logic [1:0] prev_lvl, lvl;
      int phase, mlt_bad, mlt_moves, s;
      logic [4:0] win;
      cnt = -1; bl = SEED; kprev = 1'b0; prev_lvl = 2'b00;
      phase = 0; mlt_bad = 0; mlt_moves = 0; win = '1;
      drive_slot(sel, 0);
      nib_ce = 1'b1;
      for (int i = 0; i < 5 * nslots + 4; i++) begin
         @(negedge clk);
         cnt++;
         lvl = line_sym;
         if (lvl == 2'b10) mlt_bad++;
         d = (lvl != prev_lvl);
         if (d) begin
            mlt_moves++;
            if (lvl != phase_sym(phase + 1)) mlt_bad++;
            phase = (phase + 1) & 3;
         end
         prev_lvl = lvl;
         plain = d ^ kprev;
         key = bl[10] ^ bl[8];
         bl = {bl[9:0], key};
         kprev = key;
         win = {win[3:0], plain};
         if (cnt >= 7 && (cnt % 5) == 2) begin
            s = (cnt - 7) / 5;
            if (s < nslots && s < 64)
               chk($sformatf("R%0d slot %0d (order R9, key R8)", exp_req[s], s),
                   32'(win), 32'(exp_cg[s]));
         end
         if (((cnt + 1) % 5) == 0) begin
            drive_slot(sel, (cnt + 1) / 5);
            nib_ce = 1'b1;
         end else begin
            nib_ce = 1'b0;
         end
      end
      chk("R10 illegal level steps", 32'(mlt_bad), 32'd0);
      chk("R10 line activity seen", 32'(mlt_moves > 0), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 zero level in reset", 32'(line_sym), 32'd0);
      rst_n = 1'b1;
      run_slots(1, NV1 + 3);

      // directed: reset in the middle of an active line
      @(negedge clk);
      nib_ce = 1'b0;
      tx_en  = 1'b1;
      txd    = 4'hF;
      rst_n  = 1'b0;
      @(negedge clk);
      chk("R1 zero level right after reset", 32'(line_sym), 32'd0);
      repeat (4) @(negedge clk);
      chk("R1 zero level held in reset", 32'(line_sym), 32'd0);
      rst_n = 1'b1;
      run_slots(2, NV2 + 2);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule